// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block collects up to 32 interrupt request lines into a single interrupt request for a processor. Each line has its own sensitivity, fixed when the design is elaborated. A line can respond to a rising edge, a falling edge, a high level or a low level. Every detected event sets a status bit. That bit stays latched until software acknowledges it.

Software sees the controller through a plain synchronous 32-bit register port with a byte address, a write strobe, write data and registered read data. The port gives software these controls:
- an enable mask, which can be written whole or changed bit by bit through separate set and clear registers;
- an acknowledge register;
- a vector register that names the most urgent pending source;
- a two-bit master control that gates the processor request.

A typical handler reads the vector, services that source and writes the source's bit to the acknowledge register.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, enable and master control are all zero, `irq_out` is low and the vector register reads 0xFFFF_FFFF.
- R2: The register word is chosen by address bits [4:2], and bits [1:0] are ignored. The byte offsets are: status 0, pending 4, enable 8, acknowledge 12, set-enable 16, clear-enable 20, vector 24, master 28. `reg_rdata` is loaded at the clock edge where the address is presented. Acknowledge, set-enable and clear-enable read as zero. Bits at or above NUM_SRC read as zero.
- R3: A write to the enable register (offset 8) loads the whole mask, so writing zero masks every source.
- R4: In a set-enable write (offset 16), each 1 bit sets the matching enable bit. In a clear-enable write (offset 20), each 1 bit clears it. Bits written as 0 leave their enable bits unchanged.
- R5: The sensitivity of source i is given by SENSE[2i+1:2i]. The codes are 0 rising edge, 1 falling edge, 2 active-high level and 3 active-low level. An edge source sets its status bit at the clock edge where its sampled input moves in the active direction. A transition in the other direction, or a steady input, has no effect. The bit stays set until it is acknowledged.
- R6: A level source sets its status bit at every clock edge where its input is at the active level. The bit stays latched after the input returns to idle. An acknowledge clears the bit at the acknowledge edge. If the input is still active, the bit is set again at the following edge.
- R7: A write to the acknowledge register (offset 12) clears each status bit written as 1, and writing all ones clears every source. If an edge source sees its edge at the same clock edge as its acknowledge, the edge wins and the bit stays set.
- R8: The pending register (offset 4) reads as status AND enable.
- R9: The vector register (offset 24) reads as the index of the lowest-numbered pending source, or as 0xFFFF_FFFF when nothing is pending.
- R10: In the master register (offset 28), bit 0 is the controller enable and bit 1 is the hardware-request enable. `irq_out` is high exactly when both bits are 1 and some pending bit is 1, and it follows the registered state in the same cycle.
- R11: Writes to the status, pending and vector registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| reg_addr | input | 5 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bound checker watches several rules on every cycle:
- after a set-enable write, the written enable bits are set, and after a clear-enable write they are clear;
- a level source's bit is cleared right after its acknowledge;
- an edge source's latched bit never drops without an acknowledge;
- the vector always names the lowest pending source, or all ones when none is pending;
- `irq_out` stays low unless both master bits are set.

Other behaviour depends on stimulus order, so only the bench scenarios show it. These include the per-source edge direction and the latching of levels, the one-cycle gap in the request while a still-active level is acknowledged, an edge winning over an acknowledge at the same edge, ignored writes, the address aliasing, and sweeps over all 256 enable masks of an eight-source build.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   typedef enum logic [1:0] {
      SENSE_RISE = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_HIGH = 2'd2,
      SENSE_LOW  = 2'd3
   } sense_e;

   localparam int REG_ADDR_W = 5;
   localparam int REG_DATA_W = 32;
   localparam int MAX_SRC    = 32;

   // word index = byte offset / 4
   localparam logic [2:0] WRD_STATUS  = 3'd0;
   localparam logic [2:0] WRD_PENDING = 3'd1;
   localparam logic [2:0] WRD_ENABLE  = 3'd2;
   localparam logic [2:0] WRD_ACK     = 3'd3;
   localparam logic [2:0] WRD_SETEN   = 3'd4;
   localparam logic [2:0] WRD_CLREN   = 3'd5;
   localparam logic [2:0] WRD_VECTOR  = 3'd6;
   localparam logic [2:0] WRD_MASTER  = 3'd7;

   typedef struct packed {
      logic hw_en;    // bit 1
      logic core_en;  // bit 0
   } master_t;

   function automatic logic is_edge(input sense_e m);
      return (m == SENSE_RISE) || (m == SENSE_FALL);
   endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_ctrl_pkg::*;
#(
   parameter sense_e MODE = SENSE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic ack,
   output logic stat
);

   generate
      if (is_edge(MODE)) begin : g_edge
         localparam logic IDLE_LVL = (MODE == SENSE_FALL);
         logic prev_q;
         logic stat_q;
         logic evt;

         assign evt = (MODE == SENSE_RISE) ? (din & ~prev_q) : (~din & prev_q);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= IDLE_LVL;
               stat_q <= 1'b0;
            end else begin
               prev_q <= din;
               // a fresh edge outranks an acknowledge in the same cycle
               stat_q <= evt | (stat_q & ~ack);
            end
         end
         assign stat = stat_q;
      end else begin : g_level
         logic stat_q;
         logic act;

         assign act = (MODE == SENSE_HIGH) ? din : ~din;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stat_q <= 1'b0;
            end else begin
               // acknowledge wins for one cycle; a held level re-arms after it
               stat_q <= ~ack & (stat_q | act);
            end
         end
         assign stat = stat_q;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic                  wr,
   input  logic [REG_DATA_W-1:0] wdata,
   input  logic [NUM_SRC-1:0]    status,
   input  logic [REG_DATA_W-1:0] vector,
   output logic [NUM_SRC-1:0]    ack,
   output logic [NUM_SRC-1:0]    enable,
   output logic [NUM_SRC-1:0]    pending,
   output master_t               master,
   output logic [REG_DATA_W-1:0] rdata
);

   logic [2:0]         word;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] en_q;
   master_t            mst_q;
   logic               unused_addr_lsb;

   assign word            = addr[4:2];
   assign unused_addr_lsb = ^addr[1:0];
   assign wbits           = wdata[NUM_SRC-1:0];

   assign ack     = (wr && word == WRD_ACK) ? wbits : '0;
   assign pending = status & en_q;
   assign enable  = en_q;
   assign master  = mst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         mst_q <= '0;
      end else if (wr) begin
         case (word)
            WRD_ENABLE: en_q  <= wbits;
            WRD_SETEN:  en_q  <= en_q | wbits;
            WRD_CLREN:  en_q  <= en_q & ~wbits;
            WRD_MASTER: mst_q <= master_t'(wdata[1:0]);
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         case (word)
            WRD_STATUS:  rdata <= REG_DATA_W'(status);
            WRD_PENDING: rdata <= REG_DATA_W'(status & en_q);
            WRD_ENABLE:  rdata <= REG_DATA_W'(en_q);
            WRD_VECTOR:  rdata <= vector;
            WRD_MASTER:  rdata <= REG_DATA_W'(mst_q);
            default:     rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int          NUM_SRC = 32,
   parameter logic [63:0] SENSE   = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    irq_in,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic                  reg_wr,
   input  logic [REG_DATA_W-1:0] reg_wdata,
   output logic [REG_DATA_W-1:0] reg_rdata,
   output logic                  irq_out
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_num
         $error("vec_irq_ctrl: NUM_SRC must lie in 1..32");
      end
   endgenerate

   logic [NUM_SRC-1:0]    status_w;
   logic [NUM_SRC-1:0]    ack_w;
   logic [NUM_SRC-1:0]    enable_w;
   logic [NUM_SRC-1:0]    pend_w;
   logic [REG_DATA_W-1:0] vector_w;
   master_t               master_w;
   logic                  found_w;
   logic [IDX_W-1:0]      idx_w;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         irq_src_cell #(
            .MODE (sense_e'(SENSE[2*g +: 2]))
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (irq_in[g]),
            .ack   (ack_w[g]),
            .stat  (status_w[g])
         );
      end
   endgenerate

   irq_prio_enc #(
      .NUM_SRC (NUM_SRC)
   ) u_prio (
      .req   (pend_w),
      .found (found_w),
      .idx   (idx_w)
   );

   assign vector_w = found_w ? REG_DATA_W'(idx_w) : '1;

   irq_regs #(
      .NUM_SRC (NUM_SRC)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (reg_addr),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .status  (status_w),
      .vector  (vector_w),
      .ack     (ack_w),
      .enable  (enable_w),
      .pending (pend_w),
      .master  (master_w),
      .rdata   (reg_rdata)
   );

   assign irq_out = master_w.core_en & master_w.hw_en & found_w;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
   import irq_ctrl_pkg::*;
#(
   parameter int          NUM_SRC = 32,
   parameter logic [63:0] SENSE   = '0,
   localparam int         IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [REG_ADDR_W-1:0] reg_addr,
   input logic                  reg_wr,
   input logic [REG_DATA_W-1:0] reg_wdata,
   input logic                  irq_out,
   input logic [NUM_SRC-1:0]    status_w,
   input logic [NUM_SRC-1:0]    enable_w,
   input logic [NUM_SRC-1:0]    pend_w,
   input logic [REG_DATA_W-1:0] vector_w,
   input logic [1:0]            master_w
);

   function automatic logic [NUM_SRC-1:0] edge_mask();
      logic [NUM_SRC-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_SRC; i++) m[i] = ~SENSE[2*i+1];
      return m;
   endfunction

   localparam logic [NUM_SRC-1:0] EDGE_M = edge_mask();
   localparam logic [NUM_SRC-1:0] LVL_M  = ~edge_mask();

   logic [2:0]         word;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] ack_now;
   logic [NUM_SRC-1:0] held_edges;
   logic [NUM_SRC-1:0] below_vec;
   logic               unused_chk;

   assign word       = reg_addr[4:2];
   assign unused_chk = ^{reg_addr[1:0], reg_wdata};
   assign wbits      = reg_wdata[NUM_SRC-1:0];
   assign ack_now    = (reg_wr && word == WRD_ACK) ? wbits : '0;
   assign held_edges = status_w & EDGE_M & ~ack_now;
   assign below_vec  = pend_w & ((NUM_SRC'(1) << vector_w[IDX_W-1:0]) - NUM_SRC'(1));

   // R4: set-enable bits take effect at the next edge
   assert_seten_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && word == WRD_SETEN) |=> ((enable_w & $past(wbits)) == $past(wbits)));

   // R4: clear-enable bits take effect at the next edge
   assert_clren_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && word == WRD_CLREN) |=> ((enable_w & $past(wbits)) == '0));

   // R6: a level source is clear in the cycle after its acknowledge
   assert_lvl_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_now & LVL_M) != '0 |=> ((status_w & $past(ack_now & LVL_M)) == '0));

   // R5: a latched edge bit holds until acknowledged
   assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      held_edges != '0 |=> ((status_w & $past(held_edges)) == $past(held_edges)));

   // R9: no pending source means all-ones vector
   assert_vec_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_w == '0 |-> vector_w == '1);

   // R9: vector names a pending source with none below it
   assert_vec_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_w != '0 |-> (vector_w < NUM_SRC && pend_w[vector_w[IDX_W-1:0]] && below_vec == '0));

   // R10: request gated by both master bits
   assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      master_w != 2'b11 |-> !irq_out);

endmodule

bind vec_irq_ctrl irq_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .SENSE   (SENSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .irq_out   (irq_out),
   .status_w  (status_w),
   .enable_w  (enable_w),
   .pend_w    (pend_w),
   .vector_w  (vector_w),
   .master_w  (master_w)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;

   localparam int          N     = 8;
   localparam logic [63:0] SNS   = 64'hE4E4;   // source i has code i%4
   localparam logic [7:0]  IDLE  = 8'hAA;      // idle level = code bit 0
   localparam logic [4:0]  A_ST  = 5'd0,  A_PN = 5'd4,  A_EN = 5'd8,  A_ACK = 5'd12;
   localparam logic [4:0]  A_SET = 5'd16, A_CLR = 5'd20, A_VEC = 5'd24, A_MST = 5'd28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = IDLE;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(N), .SENSE(SNS)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b0;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   function automatic logic [31:0] lowest(input logic [7:0] p);
      for (int i = 0; i < 8; i++) if (p[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_out", 32'(irq_out), 32'd0);
      rd_chk("R1 status", A_ST, 32'd0);
      rd_chk("R1 enable", A_EN, 32'd0);
      rd_chk("R1 master", A_MST, 32'd0);
      rd_chk("R1 vector", A_VEC, 32'hFFFF_FFFF);

      // R2 write-only words read zero, unused upper bits zero, low address bits ignored
      wr(A_EN, 32'hFFFF_FFFF);
      rd_chk("R2 upper bits", A_EN, 32'h0000_00FF);
      rd_chk("R2 alias", 5'd11, 32'h0000_00FF);
      rd_chk("R2 ack reads 0", A_ACK, 32'd0);
      rd_chk("R2 set reads 0", A_SET, 32'd0);
      rd_chk("R2 clr reads 0", A_CLR, 32'd0);
      wr(A_EN, 32'd0);
      rd_chk("R3 all masked", A_EN, 32'd0);

      // R3 / R4 sweep of all masks
      for (int a = 0; a < 256; a++) begin
         logic [7:0] b, c;
         b = 8'((a * 37 + 11) & 255);
         c = 8'((a * 91 + 5) & 255);
         wr(A_EN, 32'(a));
         rd_chk("R3 enable load", A_EN, 32'(a));
         wr(A_SET, 32'(b));
         rd_chk("R4 set-enable", A_EN, 32'(8'(a) | b));
         wr(A_CLR, 32'(c));
         rd_chk("R4 clear-enable", A_EN, 32'((8'(a) | b) & ~c));
      end
      wr(A_EN, 32'd0);

      // R5 / R6 per-source sensitivity
      for (int i = 0; i < N; i++) begin
         logic act;
         act = ~IDLE[i];
         if ((i % 4) < 2) begin
            irq_in[i] = act;
            rd_chk("R5 edge sets", A_ST, 32'(1 << i));
            wr(A_ACK, 32'(1 << i));
            rd_chk("R5 steady no retrigger", A_ST, 32'd0);
            irq_in[i] = IDLE[i];
            rd_chk("R5 reverse edge ignored", A_ST, 32'd0);
         end else begin
            irq_in[i] = act;
            @(negedge clk);
            irq_in[i] = IDLE[i];
            rd_chk("R6 level latched", A_ST, 32'(1 << i));
            irq_in[i] = act;
            wr(A_ACK, 32'(1 << i));
            rd_chk("R6 level re-arms", A_ST, 32'(1 << i));
            irq_in[i] = IDLE[i];
            wr(A_ACK, 32'(1 << i));
            rd_chk("R6 level cleared", A_ST, 32'd0);
         end
      end

      // R8 / R9 / R10 sweep with every status bit set
      wr(A_MST, 32'd3);
      irq_in = ~IDLE;
      repeat (2) @(negedge clk);
      rd_chk("R5 all set", A_ST, 32'h0000_00FF);
      for (int e = 0; e < 256; e++) begin
         wr(A_EN, 32'(e));
         chk("R10 irq_out", 32'(irq_out), 32'(e != 0));
         rd_chk("R8 pending", A_PN, 32'(e));
         rd_chk("R9 vector", A_VEC, lowest(8'(e)));
      end
      for (int m = 0; m < 4; m++) begin
         wr(A_MST, 32'(m));
         chk("R10 master gate", 32'(irq_out), 32'(m == 3));
         rd_chk("R10 master read", A_MST, 32'(m));
      end

      // R7 acknowledge all
      irq_in = IDLE;
      @(negedge clk);
      wr(A_ACK, 32'hFFFF_FFFF);
      rd_chk("R7 ack all", A_ST, 32'd0);
      chk("R10 nothing pending", 32'(irq_out), 32'd0);

      // R6 one-cycle gap on acknowledge of a held level
      wr(A_EN, 32'h4);
      irq_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 level raises irq", 32'(irq_out), 32'd1);
      reg_addr = A_ACK; reg_wdata = 32'h4; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R6 gap after ack", 32'(irq_out), 32'd0);
      @(negedge clk);
      chk("R6 re-raised", 32'(irq_out), 32'd1);
      irq_in[2] = 1'b0;
      wr(A_ACK, 32'h4);
      rd_chk("R6 cleared", A_ST, 32'd0);

      // R7 edge and acknowledge at the same edge: edge wins
      irq_in[0] = 1'b1;
      @(negedge clk);
      irq_in[0] = 1'b0;
      rd_chk("R7 pre", A_ST, 32'h1);
      @(negedge clk);
      irq_in[0] = 1'b1;
      reg_addr = A_ACK; reg_wdata = 32'h1; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      irq_in[0] = 1'b0;
      rd_chk("R7 edge wins", A_ST, 32'h1);
      wr(A_ACK, 32'h1);
      rd_chk("R7 plain ack", A_ST, 32'd0);

      // R11 writes to read-only words ignored
      irq_in[1] = 1'b0;
      @(negedge clk);
      irq_in[1] = 1'b1;
      wr(A_EN, 32'h0F);
      wr(A_ST, 32'd0);
      wr(A_PN, 32'd0);
      wr(A_VEC, 32'd0);
      wr(A_ST, 32'hFF);
      rd_chk("R11 status kept", A_ST, 32'h2);
      rd_chk("R11 enable kept", A_EN, 32'h0F);
      rd_chk("R11 pending kept", A_PN, 32'h2);
      rd_chk("R11 vector kept", A_VEC, 32'd1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule